// File: doc/BRIEF.md
# Disk Transfer End-Status Controller

This block supervises a word-at-a-time disk data transfer and decides how it ends. A start strobe loads a starting storage address and a word count. Each word that is committed advances the address by one and lowers the count by one. The transfer stops on the first of five end conditions, checked in a fixed priority:

- a data-service overrun;
- a storage or interface transfer error;
- a check-character mismatch;
- a track index pulse that arrives while words remain;
- the count reaching zero.

When the transfer stops, the block freezes the address register at a value that depends on why it stopped. It builds a 16-bit interrupt status word and a 16-bit extension word, and it pulses a completion interrupt for one cycle. The status words hold their value until a clear strobe or a new start.

Status bits use MSB-first numbering: status bit n is vector index 15-n. The address register never moves during the terminating cycle. After a failed word or an overrun, it therefore names the word that failed. After any other end, it points one past the last committed word, because the address only moves after a commit.

Top module: `disk_xfer_end`

## Requirements
- R1: One cycle after `start_i`, `busy_o` is 1, `addr_o`/`cnt_o` hold the loaded values and `isw_o`/`iswex_o` are 0. While idle or finished, `word_ok_i` and the end-condition inputs do not move `addr_o`, `cnt_o` or the status words.
- R2: While busy, a cycle with `word_ok_i`=1, a nonzero count and no end condition raises `addr_o` by 1 and lowers `cnt_o` by 1 at the next edge.
- R3: While busy with `cnt_o`=0 and no other end condition, the transfer ends normally. `isw_o`=16'h0014 (status bits 11 channel end and 13 device end), and `addr_o` is unchanged. A start with count 0 ends this way on its first busy cycle.
- R4: `overrun_i` while busy ends the transfer with `isw_o`=16'h3014 (status bits 2 overrun, 3 any error, 11, 13), and `addr_o` keeps the address of the word being serviced.
- R5: `xfer_err_i` while busy ends the transfer with `addr_o` unchanged. `isw_o` is 16'h1814 when `err_src_i`=1 (storage error, status bit 4) or 16'h1414 when `err_src_i`=0 (interface error, status bit 5), in addition to bits 3, 11 and 13.
- R6: `chk_err_i` while busy ends the transfer with `isw_o`=16'h1015 (bits 3, 11, 13 and 15, extension valid) and `iswex_o`=16'h0800 (extension bit 4, file data check). `iswex_o` is 0 for every other kind of end.
- R7: `index_i` while busy with a nonzero count ends the transfer with `isw_o`=16'h1214 (bit 6 incorrect length, plus bits 3, 11 and 13). With a zero count, an index pulse gives the normal end of R3.
- R8: Simultaneous end conditions resolve in the order overrun, transfer error, check error, index, count zero. A `word_ok_i` in the terminating cycle is ignored.
- R9: `irq_o` is high for exactly the one cycle in which the new status first appears. The status words then stay stable until `clear_i`, which zeroes them and returns the block to idle.
- R10: After reset all outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Load address and count, clear status, begin transfer |
| start_addr_i | input | ADDR_W | Starting data address |
| start_cnt_i | input | CNT_W | Word count |
| word_ok_i | input | 1 | Current word committed successfully |
| xfer_err_i | input | 1 | Storage or interface transfer error on current word |
| err_src_i | input | 1 | Error kind: 1 storage, 0 interface |
| chk_err_i | input | 1 | Check-character mismatch |
| overrun_i | input | 1 | Data service overrun |
| index_i | input | 1 | Track index pulse |
| clear_i | input | 1 | Status read/clear strobe |
| addr_o | output | ADDR_W | Data address register |
| cnt_o | output | CNT_W | Remaining word count |
| busy_o | output | 1 | Transfer in progress |
| isw_o | output | 16 | Interrupt status word, MSB-first numbering |
| iswex_o | output | 16 | Status extension word |
| irq_o | output | 1 | One-cycle completion interrupt |

## Verification
The assertions assume that `start_i` and `clear_i` are never high in the same cycle as an end they must not disturb. They also assume that the end-condition inputs are synchronous single-cycle pulses sampled only while busy. The stimulus drives every input at the falling edge and holds it for exactly one cycle. It never combines `start_i` with `clear_i`. It fires end conditions alone and in stacked combinations, so that every priority pairing is reached from a known address and count.

// File: rtl/disk_end_pkg.sv
package disk_end_pkg;
  typedef enum logic [1:0] {ST_IDLE, ST_RUN, ST_DONE} xfer_st_e;
  typedef enum logic [2:0] {END_NONE, END_OVR, END_XERR, END_CHK, END_IDX, END_CNT} end_kind_e;

  localparam int STAT_W = 16;

  // status bit numbering is MSB-first
  function automatic logic [STAT_W-1:0] sbit(input int n);
    return {{(STAT_W-1){1'b0}}, 1'b1} << (STAT_W - 1 - n);
  endfunction
endpackage

// File: rtl/xfer_counter.sv
module xfer_counter #(
  parameter int ADDR_W = 16,
  parameter int CNT_W  = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [CNT_W-1:0]  cnt_i,
  input  logic              step_i,
  output logic [ADDR_W-1:0] addr_o,
  output logic [CNT_W-1:0]  cnt_o,
  output logic              zero_o
);
  localparam logic [ADDR_W-1:0] ADDR_ONE = ADDR_W'(1);
  localparam logic [CNT_W-1:0]  CNT_ONE  = CNT_W'(1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      addr_o <= '0;
      cnt_o  <= '0;
    end else if (load_i) begin
      addr_o <= addr_i;
      cnt_o  <= cnt_i;
    end else if (step_i) begin
      addr_o <= addr_o + ADDR_ONE;
      cnt_o  <= cnt_o - CNT_ONE;
    end
  end

  assign zero_o = (cnt_o == '0);

  assert_step_moves_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (step_i && !load_i) |=> (addr_o == $past(addr_o) + ADDR_ONE) && (cnt_o == $past(cnt_o) - CNT_ONE));

  assert_hold_idle_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!step_i && !load_i) |=> $stable(addr_o) && $stable(cnt_o));
endmodule

// File: rtl/end_arbiter.sv
module end_arbiter
  import disk_end_pkg::*;
(
  input  logic      run_i,
  input  logic      overrun_i,
  input  logic      xfer_err_i,
  input  logic      chk_err_i,
  input  logic      index_i,
  input  logic      cnt_zero_i,
  output end_kind_e kind_o
);
  always_comb begin
    kind_o = END_NONE;
    if (run_i) begin
      if (overrun_i)                 kind_o = END_OVR;
      else if (xfer_err_i)           kind_o = END_XERR;
      else if (chk_err_i)            kind_o = END_CHK;
      else if (index_i && !cnt_zero_i) kind_o = END_IDX;
      else if (cnt_zero_i)           kind_o = END_CNT;
    end
  end
endmodule

// File: rtl/status_builder.sv
module status_builder
  import disk_end_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clr_i,
  input  end_kind_e         kind_i,
  input  logic              err_src_i,
  output logic [STAT_W-1:0] isw_o,
  output logic [STAT_W-1:0] iswex_o,
  output logic              irq_o
);
  localparam logic [STAT_W-1:0] END_BITS = sbit(11) | sbit(13);
  localparam logic [STAT_W-1:0] ANY_ERR  = sbit(3);

  logic [STAT_W-1:0] isw_d, iswex_d;

  always_comb begin
    iswex_d = '0;
    unique case (kind_i)
      END_OVR:  isw_d = END_BITS | ANY_ERR | sbit(2);
      END_XERR: isw_d = END_BITS | ANY_ERR | (err_src_i ? sbit(4) : sbit(5));
      END_CHK: begin
        isw_d   = END_BITS | ANY_ERR | sbit(15);
        iswex_d = sbit(4);
      end
      END_IDX:  isw_d = END_BITS | ANY_ERR | sbit(6);
      END_CNT:  isw_d = END_BITS;
      default:  isw_d = '0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      isw_o   <= '0;
      iswex_o <= '0;
      irq_o   <= 1'b0;
    end else begin
      irq_o <= 1'b0;
      if (clr_i) begin
        isw_o   <= '0;
        iswex_o <= '0;
      end else if (kind_i != END_NONE) begin
        isw_o   <= isw_d;
        iswex_o <= iswex_d;
        irq_o   <= 1'b1;
      end
    end
  end

  assert_irq_single_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |=> !irq_o);

  assert_status_hold_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!clr_i && kind_i == END_NONE) |=> $stable(isw_o) && $stable(iswex_o));

  assert_ext_only_chk_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (iswex_o != '0) |-> isw_o[STAT_W-1-15]);
endmodule

// File: rtl/disk_xfer_end.sv
module disk_xfer_end
  import disk_end_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int CNT_W  = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [ADDR_W-1:0] start_addr_i,
  input  logic [CNT_W-1:0]  start_cnt_i,
  input  logic              word_ok_i,
  input  logic              xfer_err_i,
  input  logic              err_src_i,
  input  logic              chk_err_i,
  input  logic              overrun_i,
  input  logic              index_i,
  input  logic              clear_i,
  output logic [ADDR_W-1:0] addr_o,
  output logic [CNT_W-1:0]  cnt_o,
  output logic              busy_o,
  output logic [15:0]       isw_o,
  output logic [15:0]       iswex_o,
  output logic              irq_o
);
  xfer_st_e  st_q;
  end_kind_e kind;
  logic      run, cnt_zero, step;

  // start and clear override any end decision in the same cycle
  assign run  = (st_q == ST_RUN) && !start_i && !clear_i;
  assign step = run && (kind == END_NONE) && word_ok_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                 st_q <= ST_IDLE;
    else if (start_i)            st_q <= ST_RUN;
    else if (clear_i)            st_q <= ST_IDLE;
    else if (kind != END_NONE)   st_q <= ST_DONE;
  end

  assign busy_o = (st_q == ST_RUN);

  xfer_counter #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_cnt (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (start_i),
    .addr_i (start_addr_i),
    .cnt_i  (start_cnt_i),
    .step_i (step),
    .addr_o (addr_o),
    .cnt_o  (cnt_o),
    .zero_o (cnt_zero)
  );

  end_arbiter u_arb (
    .run_i      (run),
    .overrun_i  (overrun_i),
    .xfer_err_i (xfer_err_i),
    .chk_err_i  (chk_err_i),
    .index_i    (index_i),
    .cnt_zero_i (cnt_zero),
    .kind_o     (kind)
  );

  status_builder u_stat (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .clr_i     (start_i | clear_i),
    .kind_i    (kind),
    .err_src_i (err_src_i),
    .isw_o     (isw_o),
    .iswex_o   (iswex_o),
    .irq_o     (irq_o)
  );

  assert_overrun_end_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && overrun_i && !start_i && !clear_i) |=>
      (isw_o == 16'h3014) && (addr_o == $past(addr_o)) && !busy_o);

  assert_irq_has_ends_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> (isw_o[4] && isw_o[2] && !busy_o));

  assert_start_clears_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |=> busy_o && (isw_o == '0) && (iswex_o == '0));

  assert_idle_ignores_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_o && !start_i) |=> $stable(addr_o) && $stable(cnt_o));

  assert_index_len_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && index_i && cnt_o != '0 && !overrun_i && !xfer_err_i && !chk_err_i
     && !start_i && !clear_i) |=> (isw_o == 16'h1214));
endmodule

// File: tb/sim_disk_xfer_end.sv
module sim_disk_xfer_end;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 0, wok = 0, xerr = 0, src = 0, chk = 0, ovr = 0, idx = 0, clr = 0;
  logic [15:0] s_addr = '0, s_cnt = '0;
  logic [15:0] addr, cnt, isw, iswex;
  logic        busy, irq;

  int checks = 0, errors = 0, cycles = 0;

  // reference model state
  int          m_st;
  logic [15:0] m_addr, m_cnt, m_isw, m_iswex;
  logic        m_irq;

  always #4 clk = ~clk;

  disk_xfer_end u0 (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .start_addr_i(s_addr), .start_cnt_i(s_cnt),
    .word_ok_i(wok), .xfer_err_i(xerr), .err_src_i(src), .chk_err_i(chk), .overrun_i(ovr),
    .index_i(idx), .clear_i(clr), .addr_o(addr), .cnt_o(cnt), .busy_o(busy),
    .isw_o(isw), .iswex_o(iswex), .irq_o(irq)
  );

  task automatic fin(input logic [15:0] w, input logic [15:0] x);
    m_isw = w; m_iswex = x; m_st = 2; m_irq = 1'b1;
  endtask

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_st = 0; m_addr = 0; m_cnt = 0; m_isw = 0; m_iswex = 0; m_irq = 0;
    end else begin
      m_irq = 1'b0;
      if (start) begin
        m_st = 1; m_addr = s_addr; m_cnt = s_cnt; m_isw = 0; m_iswex = 0;
      end else if (clr) begin
        m_st = 0; m_isw = 0; m_iswex = 0;
      end else if (m_st == 1) begin
        if (ovr)                    fin(16'h3014, 16'h0);
        else if (xerr)              fin(src ? 16'h1814 : 16'h1414, 16'h0);
        else if (chk)               fin(16'h1015, 16'h0800);
        else if (idx && m_cnt != 0) fin(16'h1214, 16'h0);
        else if (m_cnt == 0)        fin(16'h0014, 16'h0);
        else if (wok) begin
          m_addr = m_addr + 16'd1; m_cnt = m_cnt - 16'd1;
        end
      end
    end
  end

  task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h at cycle %0d", tag, act, exp, cycles);
    end
  endtask

  // per-cycle comparison against the model
  always @(negedge clk) begin
    if (rst_n) begin
      check("R2 addr", addr, m_addr);
      check("R2 cnt", cnt, m_cnt);
      check("R8 isw", isw, m_isw);
      check("R6 iswex", iswex, m_iswex);
      check("R9 irq", {15'b0, irq}, {15'b0, m_irq});
      check("R1 busy", {15'b0, busy}, {15'b0, m_st == 1});
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000) begin
      errors++;
      $display("FAIL R9 watchdog expired: actual %0d expected <20000 cycles", cycles);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  task automatic pulse(input logic w, o, x, s, c, i, cl);
    @(negedge clk);
    wok = w; ovr = o; xerr = x; src = s; chk = c; idx = i; clr = cl;
    @(negedge clk);
    wok = 0; ovr = 0; xerr = 0; chk = 0; idx = 0; clr = 0;
  endtask

  task automatic go(input logic [15:0] a, input logic [15:0] n);
    @(negedge clk);
    start = 1; s_addr = a; s_cnt = n;
    @(negedge clk);
    start = 0;
  endtask

  task automatic words(input int n);
    for (int k = 0; k < n; k++) pulse(1, 0, 0, 0, 0, 0, 0);
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    idle(2);
    rst_n = 1'b1;
    @(negedge clk);
    check("R10 reset isw", isw, 16'h0);
    check("R10 reset addr", addr, 16'h0);
    check("R10 reset busy/irq", {14'b0, busy, irq}, 16'h0);

    // normal end
    go(16'h0100, 16'd3);
    check("R1 loaded addr", addr, 16'h0100);
    check("R1 status cleared", isw, 16'h0);
    words(3);
    idle(2);
    check("R3 normal isw", isw, 16'h0014);
    check("R3 addr past last", addr, 16'h0103);
    pulse(1, 1, 1, 1, 1, 1, 0);
    idle(1);
    check("R1 done ignores inputs addr", addr, 16'h0103);
    check("R9 status held", isw, 16'h0014);
    pulse(0, 0, 0, 0, 0, 0, 1);
    check("R9 clear zeroes isw", isw, 16'h0);

    // overrun with a word commit in the same cycle
    go(16'h0200, 16'd5);
    words(2);
    pulse(1, 1, 0, 0, 0, 0, 0);
    check("R4 overrun isw", isw, 16'h3014);
    check("R4 addr at failed word", addr, 16'h0202);

    // transfer errors
    go(16'h0300, 16'd4);
    words(1);
    pulse(0, 0, 1, 1, 0, 0, 0);
    check("R5 storage err isw", isw, 16'h1814);
    check("R5 addr at failed word", addr, 16'h0301);
    go(16'h0310, 16'd4);
    pulse(0, 0, 1, 0, 0, 0, 0);
    check("R5 interface err isw", isw, 16'h1414);

    // check-character error
    go(16'h0400, 16'd4);
    words(2);
    pulse(0, 0, 0, 0, 1, 0, 0);
    check("R6 chk isw", isw, 16'h1015);
    check("R6 chk iswex", iswex, 16'h0800);
    check("R6 addr one past last", addr, 16'h0402);
    go(16'h0410, 16'd1);
    check("R1 start clears ext", iswex, 16'h0);

    // index pulse
    go(16'h0500, 16'd6);
    words(3);
    pulse(0, 0, 0, 0, 0, 1, 0);
    check("R7 index isw", isw, 16'h1214);
    check("R7 addr one past last", addr, 16'h0503);
    go(16'h0600, 16'd1);
    words(1);
    idle(1);
    check("R7 count zero before index", isw, 16'h0014);

    // priorities
    go(16'h0700, 16'd3);
    words(1);
    pulse(1, 1, 1, 1, 1, 1, 0);
    check("R8 overrun wins", isw, 16'h3014);
    go(16'h0710, 16'd3);
    pulse(1, 0, 1, 0, 1, 1, 0);
    check("R8 xfer err over chk", isw, 16'h1414);
    check("R8 word_ok ignored", addr, 16'h0710);
    go(16'h0720, 16'd3);
    pulse(1, 0, 0, 0, 1, 1, 0);
    check("R8 chk over index", isw, 16'h1015);

    // zero count start
    go(16'h0800, 16'd0);
    idle(1);
    check("R3 zero count isw", isw, 16'h0014);
    check("R3 zero count addr", addr, 16'h0800);

    // long transfer with wrap of count region
    go(16'hFFFE, 16'd4);
    words(4);
    idle(2);
    check("R2 address wraps", addr, 16'h0002);

    idle(3);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule